// File: doc/BRIEF.md
# Write-Through Data Cache with Store Buffer

This block is a small direct-mapped data cache that sits between a processor load/store port and a slower lower-level memory. It holds 1 KB as 32 lines of 32 bytes. Loads that find their line present are answered in the cycle they are presented. Loads that miss fetch the whole line from memory, one word per handshake, and then complete as hits.

Stores always go to memory, but they pass through a four-entry first-in first-out store queue. The processor therefore does not wait for each memory write. A store that finds its line present also updates the cached word. A store that misses leaves the cache untouched. Before a line fill starts, the queue is emptied, so a fill never returns data older than a store the processor has already issued.

The processor presents a request and holds the request, the address and the data until the block raises its ready output. A request completes on the clock edge where request and ready are both high. Memory requests behave the same way: the block holds its memory request, address, direction and data until the memory acknowledges. All accesses are whole 32-bit words.

Top module: `wtc_cache`

## Requirements
- R1: After reset every line is invalid and the store queue is empty. The memory request is low, and the first load to any address misses.
- R2: The address is split as follows: bits [31:10] are the tag, bits [9:5] select the line, bits [4:2] select the word, and bits [1:0] are ignored. A load hits when the selected line is valid and its tag matches. A load hit raises ready in the same cycle and returns the cached word.
- R3: A load miss keeps ready low while a line fill runs. The fill issues eight memory reads at the line-aligned address plus 0, 4, … 28, in that order. When the last word arrives, the line is marked valid with the new tag, and the held load completes as a hit.
- R4: Every accepted store enters the store queue. The queue issues memory writes in acceptance order, one word per handshake, each with a word-aligned address and the stored data.
- R5: A store that hits also writes its word into the cached line. A later load of that word returns the stored value without a memory access.
- R6: A store that misses allocates no line and changes no valid bit. A later load of that line misses.
- R7: The queue holds four stores. A store presented while four are held sees ready low, even in a cycle in which an entry drains.
- R8: No fill read is issued while the store queue holds any entry. A fill therefore returns every earlier store's data.
- R9: Once the memory request is raised, it stays high, and its address, direction and data stay unchanged until the acknowledge.
- R10: A fill into a line that holds another tag replaces that line. A load of the replaced block misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request valid |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 32 | Byte address of the access |
| cpuWdata | input | 32 | Store data word |
| cpuReady | output | 1 | Request completes this cycle |
| cpuRdata | output | 32 | Load data, valid while load and ready are high |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | 1 = word write from queue, 0 = fill read |
| memAddr | output | 32 | Word-aligned memory address |
| memWdata | output | 32 | Write data word |
| memAck | input | 1 | Memory accepts the write or returns the read word this cycle |
| memRdata | input | 32 | Read word, valid with memAck on a fill read |

## Verification
A load hit is due in its own cycle: ready and data settle combinationally. A miss is due one cycle after the eighth fill acknowledge. Before that come the queue drain and one cycle in which the block leaves the drain state. A store is accepted in the cycle it is presented unless four entries are held. Each queued write leaves on the edge of its acknowledge. The bench keeps a behavioural model of tags, queue occupancy, pending writes and both memory views. Just before every rising edge it compares ready, load data and every memory handshake with that model, so each result is checked in the exact cycle it becomes due.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_FILL
  } state_e;

  // strobes from the controller into the datapath
  typedef struct packed {
    logic bufPush;
    logic bufPop;
    logic hitWrite;
    logic fillWrite;
    logic fillDone;
    logic fillSel;
  } ctrl_t;

endpackage

// File: rtl/wtc_store_fifo.sv
module wtc_store_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 62,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign headData = slots[rdPtr];

  always_ff @(posedge clk) begin
    if (push) slots[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/wtc_datapath.sv
module wtc_datapath
  import wtc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 32,
  parameter int BUF_DEPTH  = 4,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int IDX_W   = $clog2(NUM_LINES),
  localparam int WSEL_W  = OFF_W - 2,
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int ENTRY_W = ADDR_W - 2 + 32,
  localparam int CNT_W   = $clog2(BUF_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_t                ctrl,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic [31:0]          cpuWdata,
  output logic [31:0]          cpuRdata,
  input  logic [31:0]          memRdata,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [31:0]          memWdata,
  output logic                 lineHit,
  output logic                 bufEmpty,
  output logic                 bufFull,
  output logic                 fillLast,
  output logic [CNT_W-1:0]     bufCount,
  output logic [NUM_LINES-1:0] validVec
);

  logic [IDX_W-1:0]  idx;
  logic [WSEL_W-1:0] wordSel;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] fillCnt;
  logic [ENTRY_W-1:0] headData;

  logic [TAG_W-1:0] tagMem  [NUM_LINES];
  logic [31:0]      dataMem [NUM_LINES * (LINE_BYTES / 4)];

  assign idx     = cpuAddr[OFF_W +: IDX_W];
  assign wordSel = cpuAddr[2 +: WSEL_W];
  assign tag     = cpuAddr[ADDR_W-1 -: TAG_W];

  assign lineHit  = validVec[idx] && (tagMem[idx] == tag);
  assign cpuRdata = dataMem[{idx, wordSel}];
  assign fillLast = &fillCnt;

  assign memAddr  = ctrl.fillSel ? {cpuAddr[ADDR_W-1:OFF_W], fillCnt, 2'b00}
                                 : {headData[ENTRY_W-1:32], 2'b00};
  assign memWdata = headData[31:0];

  wtc_store_fifo #(.DEPTH(BUF_DEPTH), .WIDTH(ENTRY_W)) storeQ (
    .clk      (clk),
    .rstN     (rstN),
    .push     (ctrl.bufPush),
    .pushData ({cpuAddr[ADDR_W-1:2], cpuWdata}),
    .pop      (ctrl.bufPop),
    .headData (headData),
    .empty    (bufEmpty),
    .full     (bufFull),
    .count    (bufCount)
  );

  always_ff @(posedge clk) begin
    if (ctrl.fillWrite)     dataMem[{idx, fillCnt}] <= memRdata;
    else if (ctrl.hitWrite) dataMem[{idx, wordSel}] <= cpuWdata;
    if (ctrl.fillDone)      tagMem[idx] <= tag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
      fillCnt  <= '0;
    end else begin
      if (ctrl.fillWrite) fillCnt <= fillCnt + 1'b1;
      if (ctrl.fillDone)  validVec[idx] <= 1'b1;
    end
  end

endmodule

// File: rtl/wtc_control.sv
module wtc_control
  import wtc_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  cpuReq,
  input  logic  cpuWe,
  input  logic  lineHit,
  input  logic  bufEmpty,
  input  logic  bufFull,
  input  logic  fillLast,
  input  logic  memAck,
  output logic  cpuReady,
  output logic  memReq,
  output logic  memWe,
  output ctrl_t ctrl
);

  state_e state, stateNext;
  logic   isRead, isWrite;

  assign isRead  = cpuReq && !cpuWe;
  assign isWrite = cpuReq && cpuWe;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b1;
    unique case (state)
      ST_IDLE: begin
        memReq      = !bufEmpty;
        ctrl.bufPop = memAck && !bufEmpty;
        if (isWrite) begin
          cpuReady      = !bufFull;
          ctrl.bufPush  = !bufFull;
          ctrl.hitWrite = !bufFull && lineHit;
        end else if (isRead) begin
          cpuReady = lineHit;
          if (!lineHit) stateNext = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        memReq      = !bufEmpty;
        ctrl.bufPop = memAck && !bufEmpty;
        if (bufEmpty) stateNext = ST_FILL;
      end
      ST_FILL: begin
        memReq         = 1'b1;
        memWe          = 1'b0;
        ctrl.fillSel   = 1'b1;
        ctrl.fillWrite = memAck;
        if (memAck && fillLast) begin
          ctrl.fillDone = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 32,
  parameter int BUF_DEPTH  = 4,
  localparam int CNT_W = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [31:0]       cpuWdata,
  output logic              cpuReady,
  output logic [31:0]       cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata
);

  ctrl_t                ctrl;
  logic                 lineHit, bufEmpty, bufFull, fillLast;
  logic [CNT_W-1:0]     bufCount;
  logic [NUM_LINES-1:0] validVec;

  wtc_control ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .cpuWe    (cpuWe),
    .lineHit  (lineHit),
    .bufEmpty (bufEmpty),
    .bufFull  (bufFull),
    .fillLast (fillLast),
    .memAck   (memAck),
    .cpuReady (cpuReady),
    .memReq   (memReq),
    .memWe    (memWe),
    .ctrl     (ctrl)
  );

  wtc_datapath #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
    .NUM_LINES(NUM_LINES), .BUF_DEPTH(BUF_DEPTH)
  ) dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .cpuRdata (cpuRdata),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .lineHit  (lineHit),
    .bufEmpty (bufEmpty),
    .bufFull  (bufFull),
    .fillLast (fillLast),
    .bufCount (bufCount),
    .validVec (validVec)
  );

endmodule

// File: rtl/wtc_cache_checker.sv
module wtc_cache_checker #(
  parameter int ADDR_W    = 32,
  parameter int NUM_LINES = 32,
  parameter int BUF_DEPTH = 4,
  localparam int CNT_W = $clog2(BUF_DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cpuReq,
  input logic                 cpuWe,
  input logic                 cpuReady,
  input logic                 memReq,
  input logic                 memWe,
  input logic [ADDR_W-1:0]    memAddr,
  input logic [31:0]          memWdata,
  input logic                 memAck,
  input logic                 lineHit,
  input logic                 fillLast,
  input logic [CNT_W-1:0]     bufCount,
  input logic [NUM_LINES-1:0] validVec
);

  // R8: fill reads only with an empty queue
  p_fill_after_drain_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> (bufCount == '0));

  // R7: full queue refuses stores
  p_full_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuWe && bufCount == CNT_W'(BUF_DEPTH)) |-> !cpuReady);

  // R9: request held until acknowledged
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  // R6: store miss leaves valid bits alone
  p_no_alloc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuWe && cpuReady && !lineHit) |=> $stable(validVec));

  // R3: last fill word makes the held load hit
  p_fill_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAck && fillLast) |=> lineHit);

  // R4: occupancy bound
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    bufCount <= CNT_W'(BUF_DEPTH));

endmodule

bind wtc_cache wtc_cache_checker #(
  .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .BUF_DEPTH(BUF_DEPTH)
) chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuReq   (cpuReq),
  .cpuWe    (cpuWe),
  .cpuReady (cpuReady),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .memAck   (memAck),
  .lineHit  (lineHit),
  .fillLast (fillLast),
  .bufCount (bufCount),
  .validVec (validVec)
);

// File: tb/wtc_cache_test.sv
`timescale 1ns/1ps
module wtc_cache_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic        cpuReady;
  logic [31:0] cpuRdata;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;

  always #2 clk = ~clk;

  wtc_cache uut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  logic [31:0] lowMem [logic [29:0]];
  logic [31:0] view   [logic [29:0]];
  logic [31:0] qAddr[$];
  logic [31:0] qData[$];
  logic        mValid [32];
  logic [21:0] mTag   [32];
  int nChk = 0, nBad = 0, occ = 0, fillK = 0, cycles = 0, waitCnt = 0, stallSeen = 0;
  bit slowMem = 0;
  bit prevPend = 0;
  logic [31:0] prevAddr = '0;

  function automatic logic [31:0] initWord(input logic [29:0] w);
    return {w[15:0] ^ 16'hC35A, ~w[15:0]};
  endfunction
  function automatic logic [31:0] rdLow(input logic [29:0] w);
    return lowMem.exists(w) ? lowMem[w] : initWord(w);
  endfunction
  function automatic logic [31:0] rdView(input logic [29:0] w);
    return view.exists(w) ? view[w] : initWord(w);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  // behavioural model step, evaluated just before each rising edge
  task automatic modelStep();
    logic [4:0]  idx;
    logic [21:0] tag;
    logic [29:0] w;
    bit hitExp;
    idx = cpuAddr[9:5];
    tag = cpuAddr[31:10];
    w   = cpuAddr[31:2];
    hitExp = mValid[idx] && (mTag[idx] == tag);
    if (prevPend)  // R9
      check(memReq && memAddr == prevAddr, "R9 held request", memAddr, prevAddr);
    if (cpuReq && !cpuWe) begin
      check(cpuReady == hitExp, "R3/R6/R10 load ready vs model", 32'(cpuReady), 32'(hitExp));
      if (cpuReady && hitExp)
        check(cpuRdata == rdView(w), "R2/R5 load data", cpuRdata, rdView(w));
    end
    if (cpuReq && cpuWe) begin
      check(cpuReady == (occ < 4), "R7 store ready vs occupancy", 32'(cpuReady), 32'(occ < 4));
      if (!cpuReady) stallSeen++;
    end
    if (memReq && memWe)
      check(occ > 0, "R4 write request with empty queue", 32'(occ), 32'd1);
    if (memAck && memWe && occ > 0) begin
      check(memAddr == qAddr[0], "R4 drain address", memAddr, qAddr[0]);
      check(memWdata == qData[0], "R4 drain data", memWdata, qData[0]);
      lowMem[memAddr[31:2]] = memWdata;
      void'(qAddr.pop_front());
      void'(qData.pop_front());
      occ--;
    end
    if (memAck && !memWe) begin
      check(occ == 0, "R8 fill with pending stores", 32'(occ), 32'd0);
      check(memAddr == {cpuAddr[31:5], fillK[2:0], 2'b00}, "R3 fill address",
            memAddr, {cpuAddr[31:5], fillK[2:0], 2'b00});
      fillK++;
      if (fillK == 8) begin
        mValid[idx] = 1'b1;
        mTag[idx]   = tag;
        fillK       = 0;
      end
    end
    if (cpuReq && cpuWe && cpuReady) begin
      qAddr.push_back({w, 2'b00});
      qData.push_back(cpuWdata);
      view[w] = cpuWdata;
      occ++;
    end
    prevPend = memReq && !memAck;
    prevAddr = memAddr;
  endtask

  // monitor and watchdog
  initial begin
    for (int i = 0; i < 32; i++) begin
      mValid[i] = 1'b0;
      mTag[i]   = '0;
    end
    forever begin
      @(negedge clk);
      #1;
      if (rstN) modelStep();
      cycles++;
      if (cycles > 150000) begin
        nChk++;
        nBad++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        finishRun();
      end
    end
  end

  // lower-level memory responder
  initial begin
    forever begin
      @(negedge clk);
      memAck = 1'b0;
      if (rstN && memReq) begin
        if (waitCnt == 0) begin
          memAck   = 1'b1;
          memRdata = memWe ? 32'h0 : rdLow(memAddr[31:2]);
          waitCnt  = slowMem ? 5 : int'($urandom_range(0, 2));
        end else begin
          waitCnt--;
        end
      end
    end
  end

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d);
    bit done;
    done = 0;
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    while (!done) begin
      #1;
      done = cpuReady;
      @(negedge clk);
    end
    cpuReq = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(memReq == 1'b0, "R1 no memory request after reset", 32'(memReq), 32'd0);
    @(negedge clk);
    access(0, 32'h0000_0104, '0);   // R1/R3 cold miss, line 8
    access(0, 32'h0000_0118, '0);   // R2 hit, other word
    access(0, 32'h0000_0107, '0);   // R2 low bits ignored
    access(1, 32'h0000_0108, 32'hDEAD_0001);  // R5 store hit
    access(0, 32'h0000_0108, '0);   // R5 reads updated word
    access(1, 32'h0000_2200, 32'hBEEF_0002);  // R6 store miss
    access(0, 32'h0000_2200, '0);   // R6 misses, R8 fill sees the store
    access(0, 32'h0000_0504, '0);   // R10 same line, other tag
    access(0, 32'h0000_0104, '0);   // R10 old block misses again
    slowMem = 1;
    for (int i = 0; i < 7; i++)     // R7 burst against slow memory
      access(1, 32'h0000_0300 + 32'(i * 4), 32'h5500_0000 + 32'(i));
    access(0, 32'h0000_0310, '0);   // R8 drain before fill
    check(stallSeen > 0, "R7 stall observed", 32'(stallSeen), 32'd1);
    slowMem = 0;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      a = {19'h0, 11'($urandom_range(0, 2047)), 2'b00};
      if (i % 50 == 0) slowMem = ~slowMem;
      access($urandom_range(0, 9) < 4, a, $urandom);
    end
    repeat (60) @(negedge clk);
    check(occ == 0, "R4 queue drained at end", 32'(occ), 32'd0);
    finishRun();
  end

endmodule